// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block walks a chain of 64-bit scatter-gather descriptors held in system memory. Software writes a chain, puts its first address on `start_addr` and pulses `start`. The walker reads the descriptors one at a time over a simple read request/response port. A transfer descriptor becomes an address/length request to a separate data mover. A link descriptor moves the walk to a new address. A no-op descriptor is skipped. The walk stops at the descriptor that carries the end attribute.

Each descriptor is little-endian. Bits 15:0 hold the attribute, bits 31:16 hold the byte length and bits 63:32 hold a 32-bit address. In the attribute, bit 0 marks the descriptor as valid, bit 1 marks the end of the chain and bit 2 asks for an event. Bits 5:4 select the action. If the walker reads a descriptor without the valid mark, it stops and reports an error. A descriptor with the event bit makes `irq` pulse for one cycle once that descriptor has completed.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset, `done`, `err`, `irq`, `rd_req` and `xfer_valid` are all low.
- R2: A descriptor is read as attribute = bits 15:0, length = bits 31:16, address = bits 63:32. Action code 2 (bits 5:4) raises `xfer_valid` with that address and length. The request stays stable until it is accepted with `xfer_ready`.
- R3: After any descriptor that is not a link, the next fetch is at the current address plus 8. A read request (`rd_req`, `rd_addr`) stays stable until `rd_ready`.
- R4: A length field of 0 gives `xfer_len` = 65536 on the 17-bit length output. Any other value is passed through unchanged.
- R5: Action code 3 (link) issues no transfer. Its address field becomes the next fetch address.
- R6: Action code 0 (no-op) and the reserved action code 1 issue no transfer, and the walk continues at the next address.
- R7: The descriptor with attribute bit 1 (end) is the last one processed. No further descriptor is fetched.
- R8: A fetched descriptor with attribute bit 0 clear sets `err`, issues no transfer and stops the walk. `done` stays low, so `done` and `err` are never high together.
- R9: For each descriptor with attribute bit 2 set, `irq` pulses high for exactly one cycle. For a transfer descriptor the pulse comes after its request is accepted.
- R10: `done` rises only after the last transfer request has been accepted, and no read or transfer request is pending while `done` is high.
- R11: A `start` pulse during a walk is ignored.
- R12: A `start` pulse while idle clears `done` and `err` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 32 | Address of the first descriptor |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor read address |
| rd_ready | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 64 | Read data (one descriptor) |
| xfer_valid | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Transfer buffer address |
| xfer_len | output | 17 | Transfer length in bytes (1 to 65536) |
| xfer_ready | input | 1 | Transfer request accepted |
| done | output | 1 | Chain finished normally (held until next start) |
| err | output | 1 | Invalid descriptor met (held until next start) |
| irq | output | 1 | One-cycle event pulse |

## Verification
Two things can happen in the same clock edge: the last transfer of the chain is accepted, and its descriptor carries both the event and end attributes. When that happens, `irq` and `done` must become visible together. The bench builds a chain whose final transfer descriptor has both bits set and makes the data mover delay acceptance. At the first cycle where `done` is seen high, it requires `irq` to be high as well. It also counts the `irq` pulses to confirm that the coincidence neither loses an event nor duplicates one.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int DESC_W = 64;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int XLEN_W = LEN_W + 1;
  localparam int STRIDE = DESC_W / 8;

  typedef enum logic [1:0] {
    ACT_NOP  = 2'd0,
    ACT_RSVD = 2'd1,
    ACT_XFER = 2'd2,
    ACT_LINK = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_LAUNCH = 2'd1,
    S_WAIT   = 2'd2,
    S_XFER   = 2'd3
  } walk_st_e;

  typedef struct packed {
    logic              valid;
    logic              last;
    logic              intr;
    act_e              act;
    logic [XLEN_W-1:0] len;
    logic [ADDR_W-1:0] addr;
  } desc_t;
endpackage

// File: rtl/cw_decode.sv
module cw_decode
  import cw_pkg::*;
(
  input  logic [DESC_W-1:0] raw,
  output desc_t             d
);
  logic [15:0]       attr;
  logic [LEN_W-1:0]  len_f;
  logic              unused_attr;

  assign attr        = raw[15:0];
  assign len_f       = raw[16 +: LEN_W];
  assign unused_attr = ^{attr[15:6], attr[3]};

  always_comb begin
    d.valid = attr[0];
    d.last  = attr[1];
    d.intr  = attr[2];
    d.act   = act_e'(attr[5:4]);
    d.addr  = raw[DESC_W-1 -: ADDR_W];
    if (len_f == '0) d.len = XLEN_W'(1) << LEN_W;
    else             d.len = {1'b0, len_f};
  end
endmodule

// File: rtl/cw_fetch.sv
module cw_fetch
  import cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [ADDR_W-1:0] kick_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rd_rvalid,
  input  logic [DESC_W-1:0] rd_rdata,
  output logic [DESC_W-1:0] raw,
  output logic              raw_vld
);
  logic              req_q, req_d;
  logic              wait_q, wait_d;
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DESC_W-1:0] raw_q;
  logic              cap_en;

  assign cap_en = wait_q & rd_rvalid;

  always_comb begin
    req_d  = req_q;
    wait_d = wait_q;
    vld_d  = 1'b0;
    if (kick) begin
      req_d = 1'b1;
    end else if (req_q && rd_ready) begin
      req_d  = 1'b0;
      wait_d = 1'b1;
    end
    if (cap_en) begin
      wait_d = 1'b0;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      wait_q <= 1'b0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      raw_q  <= '0;
    end else begin
      req_q  <= req_d;
      wait_q <= wait_d;
      vld_q  <= vld_d;
      if (kick)   addr_q <= kick_addr;
      if (cap_en) raw_q  <= rd_rdata;
    end
  end

  assign rd_req  = req_q;
  assign rd_addr = addr_q;
  assign raw     = raw_q;
  assign raw_vld = vld_q;

  // R3: read request held steady until accepted
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: rtl/cw_xfer.sv
module cw_xfer
  import cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [XLEN_W-1:0] ld_len,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [XLEN_W-1:0] xfer_len,
  input  logic              xfer_ready,
  output logic              ack
);
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q;
  logic [XLEN_W-1:0] len_q;

  assign ack = vld_q & xfer_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)     vld_d = 1'b1;
    else if (ack) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (load) begin
        addr_q <= ld_addr;
        len_q  <= ld_len;
      end
    end
  end

  assign xfer_valid = vld_q;
  assign xfer_addr  = addr_q;
  assign xfer_len   = len_q;

  // R2: transfer request stable until accepted
  p_xfer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));

  // R4: a request never carries a zero length
  p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_len != '0));
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rd_rvalid,
  input  logic [DESC_W-1:0] rd_rdata,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [XLEN_W-1:0] xfer_len,
  input  logic              xfer_ready,
  output logic              done,
  output logic              err,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              irq_q, irq_d;
  logic              last_q, last_d;
  logic              intr_q, intr_d;
  logic              kick, load, ack, raw_vld;
  logic [DESC_W-1:0] raw;
  desc_t             d;

  cw_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .kick(kick), .kick_addr(cur_q),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .raw(raw), .raw_vld(raw_vld)
  );

  cw_decode u_decode (.raw(raw), .d(d));

  cw_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(d.addr), .ld_len(d.len),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_ready(xfer_ready), .ack(ack)
  );

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    done_d = done_q;
    err_d  = err_q;
    irq_d  = 1'b0;
    last_d = last_q;
    intr_d = intr_q;
    kick   = 1'b0;
    load   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          cur_d  = start_addr;
          done_d = 1'b0;
          err_d  = 1'b0;
          st_d   = S_LAUNCH;
        end
      end
      S_LAUNCH: begin
        kick = 1'b1;
        st_d = S_WAIT;
      end
      S_WAIT: begin
        if (raw_vld) begin
          if (!d.valid) begin
            err_d = 1'b1;
            st_d  = S_IDLE;
          end else if (d.act == ACT_XFER) begin
            load   = 1'b1;
            last_d = d.last;
            intr_d = d.intr;
            st_d   = S_XFER;
          end else begin
            irq_d  = d.intr;
            cur_d  = (d.act == ACT_LINK) ? d.addr : cur_q + STEP;
            done_d = d.last;
            st_d   = d.last ? S_IDLE : S_LAUNCH;
          end
        end
      end
      S_XFER: begin
        if (ack) begin
          irq_d  = intr_q;
          cur_d  = cur_q + STEP;
          done_d = last_q;
          st_d   = last_q ? S_IDLE : S_LAUNCH;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      last_q <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      done_q <= done_d;
      err_q  <= err_d;
      irq_q  <= irq_d;
      last_q <= last_d;
      intr_q <= intr_d;
    end
  end

  assign done = done_q;
  assign err  = err_q;
  assign irq  = irq_q;

  // R8: normal finish and error are exclusive
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R10: nothing outstanding once finished
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!xfer_valid && !rd_req));

  // R9: event output is a single-cycle pulse
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7: no fetch issued after the walk has stopped
  p_stop_no_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || err) && !start) |=> !rd_req);
endmodule

// File: tb/desc_chain_walker_tb.sv
module desc_chain_walker_tb;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] start_addr;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ready;
  logic        rd_rvalid;
  logic [63:0] rd_rdata;
  logic        xfer_valid;
  logic [31:0] xfer_addr;
  logic [16:0] xfer_len;
  logic        xfer_ready;
  logic        done;
  logic        err;
  logic        irq;

  desc_chain_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_ready(xfer_ready), .done(done), .err(err), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] mem [0:63];
  int          checks = 0;
  int          errors = 0;
  int          fetch_cnt = 0;
  int          xcount = 0;
  int          irq_cnt = 0;
  int          xdly = 0;
  int          cyc = 0;
  logic [31:0] xl_addr [0:15];
  logic [16:0] xl_len  [0:15];
  logic        irq_at_done;
  bit          finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [15:0] attr, input logic [15:0] len,
                     input logic [31:0] addr);
    mem[idx] = {addr, len, attr};
  endtask

  task automatic clear_logs();
    fetch_cnt = 0;
    xcount    = 0;
    irq_cnt   = 0;
  endtask

  // memory model: one cycle response after an accepted request
  initial begin
    bit          pend;
    logic [5:0]  paddr;
    pend = 0; paddr = '0;
    rd_ready = 1'b1; rd_rvalid = 1'b0; rd_rdata = '0;
    forever begin
      @(negedge clk);
      rd_rvalid = 1'b0;
      if (pend) begin
        rd_rvalid = 1'b1;
        rd_rdata  = mem[paddr];
        pend      = 0;
      end
      if (rst_n && rd_req && rd_ready) begin
        pend  = 1;
        paddr = rd_addr[8:3];
        fetch_cnt++;
      end
    end
  end

  // data mover model: accepts after xdly cycles, logs requests
  initial begin
    int wcnt;
    wcnt = 0;
    xfer_ready = 1'b0;
    forever begin
      @(negedge clk);
      xfer_ready = 1'b0;
      if (rst_n && xfer_valid) begin
        if (wcnt >= xdly) begin
          xfer_ready = 1'b1;
          if (xcount < 16) begin
            xl_addr[xcount] = xfer_addr;
            xl_len[xcount]  = xfer_len;
          end
          xcount++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && irq) irq_cnt++;
    end
  end

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk);
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int n;
    n = 0;
    irq_at_done = 1'b0;
    while (!(done || err) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (done) irq_at_done = irq;
    chk(n < 3000, {tag, " walk ended"}, n, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(done == 0 && err == 0 && irq == 0, "R1 flags after reset", {done, err, irq}, 0);
    chk(rd_req == 0 && xfer_valid == 0, "R1 requests after reset", {rd_req, xfer_valid}, 0);
  endtask

  task automatic t_basic();
    put(0, 16'h0021, 16'h0200, 32'h1000_0000);
    put(1, 16'h0021, 16'h0010, 32'h2000_0040);
    put(2, 16'h0023, 16'h0000, 32'h3000_0000);
    put(3, 16'h0023, 16'h0004, 32'h4444_4444);
    clear_logs(); xdly = 2;
    pulse_start(32'h0);
    wait_end("basic");
    chk(xcount == 3, "R3 transfer count", xcount, 3);
    chk(xl_addr[0] == 32'h1000_0000 && xl_len[0] == 17'h200, "R2 first transfer", xl_addr[0], 32'h1000_0000);
    chk(xl_addr[1] == 32'h2000_0040 && xl_len[1] == 17'h10, "R3 second transfer", xl_addr[1], 32'h2000_0040);
    chk(xl_len[2] == 17'h10000, "R4 zero length is 65536", xl_len[2], 17'h10000);
    chk(xl_addr[2] == 32'h3000_0000, "R2 third address", xl_addr[2], 32'h3000_0000);
    chk(fetch_cnt == 3, "R7 no fetch past end", fetch_cnt, 3);
    chk(done == 1 && err == 0, "R10 done after last accept", {done, err}, 2);
    chk(irq_cnt == 0, "R9 no event without bit", irq_cnt, 0);
  endtask

  task automatic t_link_nop();
    put(8,  16'h0001, 16'h0008, 32'hDEAD_0000);
    put(9,  16'h0011, 16'h0008, 32'hBEEF_0000);
    put(10, 16'h0031, 16'h0008, 32'h0000_0100);
    put(11, 16'h0023, 16'h0008, 32'h5555_0000);
    put(32, 16'h0023, 16'h0004, 32'hAAAA_0000);
    clear_logs(); xdly = 0;
    pulse_start(32'h40);
    wait_end("link");
    chk(xcount == 1, "R5 R6 only one transfer", xcount, 1);
    chk(xl_addr[0] == 32'hAAAA_0000, "R5 link target executed", xl_addr[0], 32'hAAAA_0000);
    chk(fetch_cnt == 4, "R6 nop and reserved skipped, link followed", fetch_cnt, 4);
    chk(done == 1, "R5 done after linked chain", done, 1);
  endtask

  task automatic t_invalid();
    put(16, 16'h0021, 16'h0008, 32'h6000_0000);
    put(17, 16'h0020, 16'h0008, 32'h7000_0000);
    put(18, 16'h0023, 16'h0008, 32'h8000_0000);
    clear_logs(); xdly = 1;
    pulse_start(32'h80);
    wait_end("invalid");
    chk(err == 1 && done == 0, "R8 error without done", {done, err}, 1);
    chk(xcount == 1, "R8 no transfer from invalid", xcount, 1);
    chk(fetch_cnt == 2, "R8 walk stops at invalid", fetch_cnt, 2);
  endtask

  task automatic t_restart();
    // err is high from the previous walk
    clear_logs(); xdly = 0;
    @(negedge clk);
    start = 1'b1; start_addr = 32'h0;
    @(negedge clk);
    start = 1'b0;
    chk(err == 0 && done == 0, "R12 start clears flags", {done, err}, 0);
    wait_end("restart");
    chk(done == 1 && xcount == 3, "R12 restarted walk completes", xcount, 3);
  endtask

  task automatic t_irq();
    put(20, 16'h0025, 16'h0020, 32'h9000_0000);
    put(21, 16'h0005, 16'h0000, 32'h0);
    put(22, 16'h0027, 16'h0030, 32'h9100_0000);
    clear_logs(); xdly = 3;
    pulse_start(32'hA0);
    wait_end("irq");
    chk(irq_cnt == 3, "R9 one pulse per event descriptor", irq_cnt, 3);
    chk(irq_at_done == 1, "R9 R10 event with done on last accept", irq_at_done, 1);
    chk(xcount == 2, "R10 both transfers accepted", xcount, 2);
  endtask

  task automatic t_busy();
    put(24, 16'h0023, 16'h0040, 32'hB000_0000);
    clear_logs(); xdly = 20;
    pulse_start(32'hC0);
    repeat (5) @(negedge clk);
    start = 1'b1; start_addr = 32'h0;
    @(negedge clk);
    start = 1'b0;
    wait_end("busy");
    chk(xcount == 1 && xl_addr[0] == 32'hB000_0000, "R11 start ignored while busy", xl_addr[0], 32'hB000_0000);
    chk(fetch_cnt == 1, "R11 no extra fetch", fetch_cnt, 1);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    rst_n = 1'b0; start = 1'b0; start_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_link_nop();
    t_invalid();
    t_restart();
    t_irq();
    t_busy();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule